// File: doc/BRIEF.md
# Local Interrupt Priority Selector

This block decides, each cycle, whether a hart should take a local interrupt now and which one. It takes the raw pending and enable vectors, a per-interrupt delegation mask, the current privilege level, and the machine and supervisor global enable bits. From these it forms a set of eligible interrupts. It passes each one through the machine or the supervisor gate, and then picks the survivor with the lowest bit index.

The global gates depend on privilege. Code running below a given level can always be interrupted by that level. Code running at that level can be interrupted only when that level's global enable is set. Delegated interrupts answer to the supervisor gate and the others answer to the machine gate. The decision and its cause number are registered, so they appear one clock after the inputs that produced them. The trap sequence that follows is handled elsewhere in the pipeline.

Top module: `irq_pick`

## Requirements
- R1: An interrupt is a candidate only when both its pending bit and its enable bit are 1. A pending bit whose enable bit is 0 is never selected.
- R2: Privilege is encoded as user = 0, supervisor = 1, machine = 3. For a candidate whose delegation bit is 0, the gate is open at user or supervisor privilege. At machine privilege it is open only when `m_gie_i` is 1.
- R3: For a candidate whose delegation bit is 1, the gate is open at user privilege, open at supervisor privilege only when `s_gie_i` is 1, and always closed at machine privilege.
- R4: Each candidate is gated only by the gate that its own delegation bit selects. A closed supervisor gate does not block a non-delegated candidate, and a closed machine gate does not block a delegated one below machine privilege.
- R5: When several candidates pass their gates, `cause_o` is the lowest bit index among them.
- R6: When no candidate passes its gate, `take_o` is 0 and `cause_o` is 0.
- R7: The privilege encoding 2 behaves exactly like user privilege.
- R8: `take_o` and `cause_o` reflect the inputs present at the previous rising clock edge, and do not change between edges.
- R9: While `rst_n` is low, `take_o` is 0 and `cause_o` is 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 16 | Pending interrupt bits |
| en_i | input | 16 | Per-interrupt enable bits |
| deleg_i | input | 16 | Delegation bits; 1 routes the interrupt to the supervisor gate |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 2 as user, 3 machine) |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | Registered: an interrupt should be taken |
| cause_o | output | 4 | Registered: index of the selected interrupt, 0 when none |

## Verification
The vector table pairs patterns that differ in one factor only. A pending bit is tried with its enable set and then cleared. Machine privilege is tried with its global enable set and then cleared. A delegated interrupt is tried at machine, at supervisor with and without `s_gie_i`, and at the encoding 2, which separates it from supervisor. A mixed pattern with one delegated and one non-delegated bit shows that each bit follows only its own gate. All-ones and top-bit-only patterns exercise both ends of the priority search, and index 0 winning shows that `take_o` rather than `cause_o` carries the "none" case. Directed steps cover reset with live inputs and the one-cycle latency.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // Reserved encoding folds onto user level.
  function automatic priv_e priv_fold(input logic [1:0] raw);
    priv_e lvl;
    case (raw)
      2'd1:    lvl = PRIV_SUPER;
      2'd3:    lvl = PRIV_MACH;
      default: lvl = PRIV_USER;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/irq_gate_unit.sv
module irq_gate_unit
  import irq_pick_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [NUM_IRQ-1:0] deleg,
  input  logic [1:0]         priv,
  input  logic               m_gie,
  input  logic               s_gie,
  output logic [NUM_IRQ-1:0] live
);

  priv_e lvl;
  logic  m_open;
  logic  s_open;

  always_comb begin
    lvl    = priv_fold(priv);
    m_open = (lvl != PRIV_MACH) || m_gie;
    s_open = (lvl == PRIV_USER) || ((lvl == PRIV_SUPER) && s_gie);
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    always_comb begin
      live[g] = pend[g] & en[g] & (deleg[g] ? s_open : m_open);
    end
  end

endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] vec,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  logic [NUM_IRQ:0]   seen;
  logic [NUM_IRQ-1:0] first;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chain
    assign first[g]  = vec[g] & ~seen[g];
    assign seen[g+1] = seen[g] | vec[g];
  end

  assign any = seen[NUM_IRQ];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (first[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_IRQ  = 16,
  localparam int CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o
);

  logic [NUM_IRQ-1:0] live;
  logic               any_live;
  logic [CAUSE_W-1:0] win_idx;

  logic               take_d, take_q;
  logic [CAUSE_W-1:0] cause_d, cause_q;
  logic               cause_en;

  irq_gate_unit #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .pend  (pend_i),
    .en    (en_i),
    .deleg (deleg_i),
    .priv  (priv_i),
    .m_gie (m_gie_i),
    .s_gie (s_gie_i),
    .live  (live)
  );

  irq_lowest_enc #(.NUM_IRQ(NUM_IRQ)) u_enc (
    .vec (live),
    .any (any_live),
    .idx (win_idx)
  );

  // Next state
  always_comb begin
    take_d   = any_live;
    cause_d  = any_live ? win_idx : '0;
    cause_en = take_d | take_q;   // cause is already 0 when idle stays idle
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      take_q <= take_d;
      if (cause_en) cause_q <= cause_d;
    end
  end

  assign take_o  = take_q;
  assign cause_o = cause_q;

endmodule

// File: rtl/irq_pick_chk.sv
module irq_pick_chk #(
  parameter int NUM_IRQ  = 16,
  localparam int CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] pend_i,
  input logic [NUM_IRQ-1:0] en_i,
  input logic [NUM_IRQ-1:0] deleg_i,
  input logic [1:0]         priv_i,
  input logic               m_gie_i,
  input logic               s_gie_i,
  input logic               take_o,
  input logic [CAUSE_W-1:0] cause_o
);

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_i & en_i) == '0) |=> !take_o); // R1

  AST_MACH_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd3 && !m_gie_i) |=> !take_o); // R2

  AST_SUPER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd1 && !s_gie_i && (pend_i & en_i & ~deleg_i) == '0) |=> !take_o); // R3

  AST_USER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((priv_i == 2'd0 || priv_i == 2'd2) && (pend_i & en_i) != '0) |=> take_o); // R7

  AST_WIN_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((($past(pend_i & en_i) >> cause_o) & {{(NUM_IRQ-1){1'b0}}, 1'b1}) != '0)); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (cause_o == '0)); // R6

endmodule

bind irq_pick irq_pick_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (.*);

// File: tb/sim_irq_pick.sv
module sim_irq_pick;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pend, en, deleg;
  logic [1:0]  priv;
  logic        mgie, sgie;
  logic        take;
  logic [3:0]  cause;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_pick u0 (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .m_gie_i(mgie), .s_gie_i(sgie), .take_o(take), .cause_o(cause)
  );

  typedef struct packed {
    logic [15:0] p;
    logic [15:0] e;
    logic [15:0] d;
    logic [1:0]  pv;
    logic        mg;
    logic        sg;
    logic        xt;
    logic [3:0]  xc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{16'h0020, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd5 },  // R1 R2
    '{16'h0020, 16'hFFDF, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0 },  // R1
    '{16'h0880, 16'hFFFF, 16'h0000, 2'd3, 1'b0, 1'b1, 1'b0, 4'd0 },  // R2
    '{16'h0880, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd7 },  // R2
    '{16'h0200, 16'hFFFF, 16'h0200, 2'd3, 1'b1, 1'b1, 1'b0, 4'd0 },  // R3
    '{16'h0200, 16'hFFFF, 16'h0200, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0 },  // R3
    '{16'h0200, 16'hFFFF, 16'h0200, 2'd1, 1'b0, 1'b1, 1'b1, 4'd9 },  // R3
    '{16'h0202, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b0, 1'b1, 4'd9 },  // R4
    '{16'h0002, 16'hFFFF, 16'h0002, 2'd2, 1'b0, 1'b0, 1'b1, 4'd1 },  // R7
    '{16'h0002, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b0, 1'b0, 4'd0 },  // R7
    '{16'h8000, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd15},  // R5
    '{16'hFFFF, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd0 },  // R5 R6
    '{16'h8001, 16'h8000, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd15},  // R1 R5
    '{16'hA000, 16'hFFFF, 16'h2000, 2'd3, 1'b1, 1'b1, 1'b1, 4'd15}   // R3 R4
  };

  task automatic chk(input string req, input logic xt, input logic [3:0] xc);
    n_run++;
    if (take !== xt || cause !== xc) begin
      n_fail++;
      $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
               req, take, cause, xt, xc);
    end
  endtask

  task automatic drive(input vec_t v);
    pend = v.p; en = v.e; deleg = v.d; priv = v.pv; mgie = v.mg; sgie = v.sg;
  endtask

  initial begin
    rst_n = 1'b0;
    pend = 16'hFFFF; en = 16'hFFFF; deleg = 16'h0; priv = 2'd0; mgie = 1'b1; sgie = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset with live inputs", 1'b0, 4'd0);
    pend = 16'h0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 idle after reset", 1'b0, 4'd0);

    // table walk: drive at negedge, one edge later sample at negedge
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      chk($sformatf("R1-set vector %0d", i), TBL[i].xt, TBL[i].xc);
    end

    // R8: latency; from idle, new input shows only after the next edge
    pend = 16'h0; en = 16'hFFFF; deleg = 16'h0; priv = 2'd0;
    @(negedge clk);
    chk("R6 idle before latency step", 1'b0, 4'd0);
    pend = 16'h0008;
    #2;
    chk("R8 no change before edge", 1'b0, 4'd0);
    @(negedge clk);
    chk("R8 updated after one edge", 1'b1, 4'd3);

    // R6: winner clears back to none
    pend = 16'h0;
    @(negedge clk);
    chk("R6 cause returns to zero", 1'b0, 4'd0);

    // R9: asynchronous reset mid-run
    pend = 16'h0400;
    @(negedge clk);
    chk("R2 user takes index 10", 1'b1, 4'd10);
    #2 rst_n = 1'b0;
    #1;
    chk("R9 async clear", 1'b0, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 resumes after release", 1'b1, 4'd10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: take=%0b cause=%0d expected completion", take, cause);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule